// File: doc/BRIEF.md
# Sequential Buffer Address Pointer Controller

This block produces the 12-bit word address for the clocked sequential port of a 4096 x 16 buffer memory. On each rising clock edge the pointer can advance by one, take a value captured from the sequential data bus one cycle earlier, or be reloaded from one of two stored start addresses. Two comparators watch each increment against two separate end addresses and pull an active-low end flag down on a match. The flag then stays low until software clears it or the block is reset.

A small synchronous command port writes the start, end and flag-clear registers through a 3-bit register address. The same clock edge also registers the read and write strobes for the memory array from the sequential chip-enable, read/write and output-enable inputs. The array, the pad drivers and the random-access path sit outside this block.

Top module: `seqbuf_ptr_ctrl`

## Requirements
- R1: On a rising edge with `cnt_en_n` low and no load or reload taking effect, `ptr` advances by one, whatever the level of `ce_n`. With `cnt_en_n` high and nothing else active, `ptr` holds its value.
- R2: Advancing from 4095 gives 0.
- R3: A rising edge with `ld_n` low captures `seq_din[11:0]`. `ptr` takes that value on the next rising edge, one cycle later.
- R4: A rising edge with `strt1_n` low loads `ptr` from start register 1, which is at command address 0. With only `strt2_n` low, `ptr` is loaded from start register 2, which is at command address 1. When both are low, start register 1 wins.
- R5: Within one edge the sources rank as follows: a pending delayed load first, then a start reload, then an increment.
- R6: `seq_err` is high whenever a start strobe is low while `ld_n` is low, or in the cycle after an edge that sampled `ld_n` low. Otherwise it is low.
- R7: `eob1_n` goes low on the edge where an increment makes `ptr` equal to end register 1, which is at command address 2. `eob2_n` does the same with end register 2, which is at command address 3. Loads and reloads that land on an end address do not set a flag. A flag that is low stays low.
- R8: A command write to address 5 sets `eob1_n` high when `cmd_data[0]` is 0, and sets `eob2_n` high when `cmd_data[1]` is 0. A bit at 1 leaves its flag alone. If a match and a clear fall on the same edge, the match wins.
- R9: A command write takes effect on a rising edge with `cmd_sel_n` low and `cmd_wr` high, and stores `cmd_data[11:0]`. With `cmd_sel_n` high the write is ignored. All command registers reset to zero.
- R10: After a rising edge that sampled `ce_n` and `rw_n` both low, `mem_we` is high. After an edge that sampled `ce_n` low, `rw_n` high and `oe_n` low, `mem_re` is high. After any other edge, both strobes are low.
- R11: Bringing `rst_n` low, asynchronously, sets `ptr` to 0, both flags high and both strobes low, clears any pending load, and zeroes all command registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequential port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en_n | input | 1 | Increment enable, active low |
| ld_n | input | 1 | Delayed pointer load strobe, active low |
| strt1_n | input | 1 | Reload from start register 1, active low |
| strt2_n | input | 1 | Reload from start register 2, active low |
| seq_din | input | 16 | Sequential data bus; bits 11:0 carry the load value |
| ce_n | input | 1 | Sequential chip enable, active low |
| rw_n | input | 1 | High selects read, low selects write |
| oe_n | input | 1 | Output enable, active low |
| cmd_sel_n | input | 1 | Command port select, active low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_addr | input | 3 | Command register address |
| cmd_data | input | 16 | Command write data |
| ptr | output | 12 | Current buffer address |
| eob1_n | output | 1 | End flag 1, active low, sticky |
| eob2_n | output | 1 | End flag 2, active low, sticky |
| mem_we | output | 1 | Registered array write strobe |
| mem_re | output | 1 | Registered array read strobe |
| seq_err | output | 1 | Illegal start strobe near a load |

## Verification
The pointer, both flags and both strobes are registered, so each shows the effect of the inputs one edge after they are sampled. A delayed load reaches `ptr` two edges after `ld_n` is sampled low. `seq_err` is combinational, so the bench checks it in the same cycle, 1 ns after driving the inputs. A driver task steps a reference model for each edge and queues the expected registered outputs. A monitor pops one item at each falling edge, half a cycle after the edge that produced it, so a load is scored against the item queued for the second edge.

// File: rtl/seqbuf_ptr_ctrl.sv
module seqbuf_ptr_ctrl #(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int RAW       = 3,
  parameter int CLR_ADDR  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en_n,
  input  logic           ld_n,
  input  logic           strt1_n,
  input  logic           strt2_n,
  input  logic [DW-1:0]  seq_din,
  input  logic           ce_n,
  input  logic           rw_n,
  input  logic           oe_n,
  input  logic           cmd_sel_n,
  input  logic           cmd_wr,
  input  logic [RAW-1:0] cmd_addr,
  input  logic [DW-1:0]  cmd_data,
  output logic [AW-1:0]  ptr,
  output logic           eob1_n,
  output logic           eob2_n,
  output logic           mem_we,
  output logic           mem_re,
  output logic           seq_err
);

  localparam logic [RAW-1:0] A_ST1 = RAW'(0);
  localparam logic [RAW-1:0] A_ST2 = RAW'(1);
  localparam logic [RAW-1:0] A_EN1 = RAW'(2);
  localparam logic [RAW-1:0] A_EN2 = RAW'(3);
  localparam logic [RAW-1:0] A_CLR = RAW'(CLR_ADDR);

  logic [AW-1:0] ptr_q, ptr_d, ptr_inc, ld_val_q;
  logic [AW-1:0] st1_q, st2_q, end1_q, end2_q;
  logic          ld_pend_q, eob1_q, eob2_q, we_q, re_q;

  wire strt_any = ~strt1_n | ~strt2_n;
  wire do_inc   = ~ld_pend_q & ~strt_any & ~cnt_en_n;
  wire cmd_go   = ~cmd_sel_n & cmd_wr;
  wire clr1     = cmd_go & (cmd_addr == A_CLR) & ~cmd_data[0];
  wire clr2     = cmd_go & (cmd_addr == A_CLR) & ~cmd_data[1];
  wire hit1     = do_inc & (ptr_inc == end1_q);
  wire hit2     = do_inc & (ptr_inc == end2_q);

  assign ptr_inc = ptr_q + 1'b1;
  assign seq_err = strt_any & (~ld_n | ld_pend_q);

  always_comb begin
    if (ld_pend_q)     ptr_d = ld_val_q;
    else if (!strt1_n) ptr_d = st1_q;
    else if (!strt2_n) ptr_d = st2_q;
    else if (do_inc)   ptr_d = ptr_inc;
    else               ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      ld_pend_q <= 1'b0;
      ld_val_q  <= '0;
    end else begin
      ptr_q     <= ptr_d;
      ld_pend_q <= ~ld_n;
      if (!ld_n) ld_val_q <= seq_din[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q  <= '0;
      st2_q  <= '0;
      end1_q <= '0;
      end2_q <= '0;
    end else if (cmd_go) begin
      case (cmd_addr)
        A_ST1:   st1_q  <= cmd_data[AW-1:0];
        A_ST2:   st2_q  <= cmd_data[AW-1:0];
        A_EN1:   end1_q <= cmd_data[AW-1:0];
        A_EN2:   end2_q <= cmd_data[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eob1_q <= 1'b1;
      eob2_q <= 1'b1;
    end else begin
      if (hit1)      eob1_q <= 1'b0;
      else if (clr1) eob1_q <= 1'b1;
      if (hit2)      eob2_q <= 1'b0;
      else if (clr2) eob2_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
    end else begin
      we_q <= ~ce_n & ~rw_n;
      re_q <= ~ce_n & rw_n & ~oe_n;
    end
  end

  assign ptr    = ptr_q;
  assign eob1_n = eob1_q;
  assign eob2_n = eob2_q;
  assign mem_we = we_q;
  assign mem_re = re_q;

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == {AW{1'b1}} && !cnt_en_n && !ld_pend_q && strt1_n && strt2_n) |=> ptr == '0);

  // R3
  delayed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> ##1 ptr == $past(seq_din[AW-1:0], 2));

  // R6
  start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ld_n) && !strt1_n) |-> seq_err);

  // R7
  flag1_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eob1_n) |-> ptr == end1_q);

  // R7
  flag2_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eob2_n) |-> ptr == end2_q);

  // R10
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(!ce_n && !rw_n));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

endmodule

// File: tb/seqbuf_ptr_ctrl_tb.sv
`timescale 1ns/1ps
module seqbuf_ptr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en_n, ld_n, strt1_n, strt2_n, ce_n, rw_n, oe_n, cmd_sel_n, cmd_wr;
  logic [15:0] seq_din, cmd_data;
  logic [2:0]  cmd_addr;
  logic [11:0] ptr;
  logic eob1_n, eob2_n, mem_we, mem_re, seq_err;

  always #2.5 clk = ~clk;

  seqbuf_ptr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
    .strt1_n(strt1_n), .strt2_n(strt2_n), .seq_din(seq_din),
    .ce_n(ce_n), .rw_n(rw_n), .oe_n(oe_n), .cmd_sel_n(cmd_sel_n),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n), .mem_we(mem_we),
    .mem_re(mem_re), .seq_err(seq_err));

  typedef struct {
    logic [11:0] p;
    logic f1, f2, we, re;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  logic [11:0] m_p, m_ld, m_s1, m_s2, m_e1, m_e2;
  logic m_pend, m_f1, m_f2;

  task automatic model_reset();
    m_p = 0; m_ld = 0; m_s1 = 0; m_s2 = 0; m_e1 = 0; m_e2 = 0;
    m_pend = 0; m_f1 = 1; m_f2 = 1;
  endtask

  task automatic idle();
    cnt_en_n = 1; ld_n = 1; strt1_n = 1; strt2_n = 1; seq_din = 0;
    ce_n = 1; rw_n = 1; oe_n = 1; cmd_sel_n = 1; cmd_wr = 0;
    cmd_addr = 0; cmd_data = 0;
  endtask

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic tick();
    logic exp_err, inc, hit1, hit2;
    logic [11:0] np;
    exp_t e;
    #1;
    exp_err = (!strt1_n || !strt2_n) && (!ld_n || m_pend);
    chk({tag, " seq_err R6"}, {31'b0, seq_err}, {31'b0, exp_err});
    inc = 0;
    if (m_pend)        np = m_ld;
    else if (!strt1_n) np = m_s1;
    else if (!strt2_n) np = m_s2;
    else if (!cnt_en_n) begin np = m_p + 12'd1; inc = 1; end
    else               np = m_p;
    hit1 = inc && (np == m_e1);
    hit2 = inc && (np == m_e2);
    if (!cmd_sel_n && cmd_wr && cmd_addr == 3'd5) begin
      if (!cmd_data[0]) m_f1 = 1;
      if (!cmd_data[1]) m_f2 = 1;
    end
    if (hit1) m_f1 = 0;
    if (hit2) m_f2 = 0;
    if (!cmd_sel_n && cmd_wr) begin
      case (cmd_addr)
        3'd0: m_s1 = cmd_data[11:0];
        3'd1: m_s2 = cmd_data[11:0];
        3'd2: m_e1 = cmd_data[11:0];
        3'd3: m_e2 = cmd_data[11:0];
        default: ;
      endcase
    end
    if (!ld_n) m_ld = seq_din[11:0];
    m_pend = !ld_n;
    m_p = np;
    e.p = np; e.f1 = m_f1; e.f2 = m_f2;
    e.we = !ce_n && !rw_n; e.re = !ce_n && rw_n && !oe_n; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    idle();
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " ptr"},    {20'b0, ptr},   {20'b0, e.p});
      chk({e.tag, " eob1_n"}, {31'b0, eob1_n}, {31'b0, e.f1});
      chk({e.tag, " eob2_n"}, {31'b0, eob2_n}, {31'b0, e.f2});
      chk({e.tag, " mem_we"}, {31'b0, mem_we}, {31'b0, e.we});
      chk({e.tag, " mem_re"}, {31'b0, mem_re}, {31'b0, e.re});
    end
  end

  task automatic cmd(logic [2:0] a, logic [15:0] d);
    cmd_sel_n = 0; cmd_wr = 1; cmd_addr = a; cmd_data = d;
    tick();
  endtask

  task automatic check_reset_state();
    chk("R11 ptr", {20'b0, ptr}, 32'h0);
    chk("R11 eob1_n", {31'b0, eob1_n}, 32'h1);
    chk("R11 eob2_n", {31'b0, eob2_n}, 32'h1);
    chk("R11 strobes", {30'b0, mem_we, mem_re}, 32'h0);
  endtask

  initial begin
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1;
    @(negedge clk);

    tag = "R9";
    cmd(3'd0, 16'h0100);
    cmd(3'd1, 16'h07F0);
    cmd(3'd2, 16'h0103);
    cmd(3'd3, 16'h0FFE);
    cmd_sel_n = 1; cmd_wr = 1; cmd_addr = 3'd0; cmd_data = 16'h0555; tick();

    tag = "R1";
    tick();
    for (int i = 0; i < 3; i++) begin cnt_en_n = 0; ce_n = (i != 1); tick(); end

    tag = "R4";
    strt1_n = 0; tick();
    tag = "R7";
    for (int i = 0; i < 5; i++) begin cnt_en_n = 0; tick(); end
    tag = "R4";
    strt2_n = 0; cnt_en_n = 0; tick();
    strt1_n = 0; strt2_n = 0; tick();
    tag = "R7";
    strt1_n = 0; strt2_n = 1; tick();

    tag = "R8";
    cmd(3'd5, 16'h0002);
    cmd(3'd5, 16'h0003);

    tag = "R3";
    ld_n = 0; seq_din = 16'hAFFD; cnt_en_n = 0; tick();
    tag = "R5";
    strt2_n = 0; cnt_en_n = 0; tick();
    tag = "R7";
    cnt_en_n = 0; tick();
    tag = "R2";
    cnt_en_n = 0; tick();
    cnt_en_n = 0; tick();
    cnt_en_n = 0; tick();

    tag = "R6";
    ld_n = 0; seq_din = 16'h0ABC; strt1_n = 0; tick();
    tag = "R3";
    tick();
    tick();

    tag = "R8";
    cmd(3'd5, 16'h0001);
    strt1_n = 0; tick();
    cnt_en_n = 0; cnt_en_n = 0; tick();
    cnt_en_n = 0; tick();
    cnt_en_n = 0; cmd_sel_n = 0; cmd_wr = 1; cmd_addr = 3'd5; cmd_data = 0; tick();

    tag = "R10";
    ce_n = 0; rw_n = 0; tick();
    ce_n = 0; rw_n = 1; oe_n = 0; tick();
    ce_n = 0; rw_n = 1; oe_n = 1; tick();
    ce_n = 1; rw_n = 0; oe_n = 0; tick();
    ce_n = 0; rw_n = 0; cnt_en_n = 0; tick();

    @(negedge clk);
    ld_n = 0; seq_din = 16'h0123;
    #1 rst_n = 0;
    #1 model_reset();
    check_reset_state();
    @(negedge clk);
    rst_n = 1;
    idle();
    tag = "R11";
    tick();
    strt1_n = 0; tick();
    cnt_en_n = 0; tick();

    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) chk("queue drained", q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", q.size());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule